// File: doc/BRIEF.md
# POS HDLC Transmit Framer

This block turns packets held in a byte-wide, show-ahead transmit FIFO into the continuous octet stream that fills a SONET/SDH payload envelope. It emits exactly one byte per clock. When no packet is being sent, the stream carries flag bytes. A frame can be prefixed with generated address and control octets. It can be closed with a 16-bit or 32-bit frame check sequence, or with none. That check sequence can be corrupted on purpose, either for a single frame or for every frame. Flag and escape values inside a frame are octet-stuffed. The finished stream can pass through a self-synchronous scrambler.

Configuration arrives on static control pins. The error-injection request is a small piece of state inside the block, set and cleared by pulses. Its level is visible on an output, so the one-shot self-clear can be observed. Section overhead, pointers, the FIFO and gap-based flow control belong to neighbouring blocks.

Top module: `posTxFramer`

## Requirements
- R1: Outside a frame each byte before scrambling is the flag 0x7E. Every frame is opened and closed by a flag, so consecutive frames are separated by at least one flag.
- R2: While `cfgReadEn` is 0 and no frame is in progress, `fifoRd` stays 0 even if the FIFO holds a packet, and only flags are sent. Once it is 1, waiting packets are read and sent.
- R3: With `cfgAcPass` = 0 every frame begins with the generated octets 0xFF then 0x03, followed by the FIFO bytes. With `cfgAcPass` = 1 the FIFO bytes are sent unchanged with nothing prepended.
- R4: `cfgFcsSel` selects the check sequence: 2'b00 none, 2'b01 reserved (treated as none), 2'b10 CRC-16 (reflected polynomial 0x8408), 2'b11 CRC-32 (reflected polynomial 0xEDB88320). The CRC is preset to all ones and covers address, control and information. It is sent ones-complemented, least significant byte first.
- R5: Inside a frame, FCS included, a 0x7E or 0x7D byte is sent as 0x7D followed by that byte XOR 0x20.
- R6: With `cfgErrMode` = 0 and the request set (`errInjActive` = 1), the next frame that carries an FCS is sent with its FCS bit-inverted. The request then clears itself.
- R7: With `cfgErrMode` = 1 and the request set, every frame with an FCS is sent inverted. The request stays set until `errInjClr` is pulsed.
- R8: When no FCS is selected, no error is inserted and a pending request is left untouched.
- R9: With `cfgScrEn` = 1 each output bit, taken LSB first within a byte, is the input bit XOR the output bit sent 43 bit times earlier. Flags are scrambled too. With `cfgScrEn` = 0 the stream passes through unchanged.
- R10: `fifoRd` is asserted only while `fifoValid` is 1 and an information byte is being taken. It is never asserted while an escape second byte or an FCS byte is going out, so each FIFO byte is read exactly once.
- R11: During reset `txData` is 0x7E, `fifoRd` is 0 and `errInjActive` is 0. The scrambler history starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgReadEn | input | 1 | Allow packets to be taken from the FIFO |
| cfgFcsSel | input | 2 | Check sequence type: 00 none, 01 reserved, 10 CRC-16, 11 CRC-32 |
| cfgErrMode | input | 1 | 0: one-shot FCS corruption, 1: sticky |
| cfgAcPass | input | 1 | 1: address and control come from the FIFO |
| cfgScrEn | input | 1 | Enable the 1 + x^43 scrambler |
| errInjSet | input | 1 | Pulse that sets the FCS corruption request |
| errInjClr | input | 1 | Pulse that clears the request (wins over set) |
| errInjActive | output | 1 | Current level of the corruption request |
| fifoData | input | 8 | Head byte of the FIFO |
| fifoSop | input | 1 | Head byte is the first of a packet |
| fifoEop | input | 1 | Head byte is the last of a packet |
| fifoValid | input | 1 | FIFO head is valid |
| fifoRd | output | 1 | Head byte consumed at this clock edge |
| txData | output | 8 | Registered payload byte, one per clock |

## Verification
The checks assume that a packet is presented contiguously: once its start byte is taken, `fifoValid` stays high until its end byte has been read. They also assume that the configuration pins and the error-request pulses change only while no frame is in flight. The bench meets both conditions by loading each packet into its FIFO model in one step. It changes configuration only across a reset or while the line is idle, and it pulses the request controls only between bursts. Expected frames are rebuilt from the sent packets with a bench CRC. They are compared after descrambling and unstuffing the observed stream.

// File: rtl/posTxPkg.sv
package posTxPkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_BYTE  = 8'h7D;
  localparam logic [BYTE_W-1:0] ESC_FLIP  = 8'h20;
  localparam logic [BYTE_W-1:0] ADDR_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] CTRL_BYTE = 8'h03;

  localparam logic [31:0] POLY_32 = 32'hEDB88320;
  localparam logic [31:0] POLY_16 = 32'h00008408;

  // source of the byte offered to the stuffer in the current cycle
  typedef enum logic [2:0] {
    SEL_FLAG,
    SEL_ADDR,
    SEL_CTRL,
    SEL_DATA,
    SEL_FCS
  } byteSelT;

  // strobes from control to datapath
  typedef struct packed {
    byteSelT    sel;
    logic       frameByte;  // byte belongs to a frame: subject to stuffing
    logic       crcInit;    // preset the CRC
    logic       crcUpd;     // fold the offered byte into the CRC
    logic [1:0] fcsIdx;     // which FCS byte to offer
    logic       fcsInvert;  // corrupt the check sequence of this frame
    logic       crc32;      // width of the running check
  } txStrobeT;

  // one byte of a reflected CRC, LSB first
  function automatic logic [31:0] crcStep(input logic [31:0] crcIn,
                                          input logic [7:0]  din,
                                          input logic        wide);
    logic [31:0] c;
    logic        fb;
    c = wide ? crcIn : {16'h0000, crcIn[15:0]};
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ din[i];
      c  = c >> 1;
      if (fb) c = c ^ (wide ? POLY_32 : POLY_16);
    end
    return c;
  endfunction

endpackage

// File: rtl/posTxScrambler.sv
module posTxScrambler #(
  parameter int W   = 8,
  parameter int LAG = 43
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);

  logic [LAG-1:0] hist;
  logic [LAG-1:0] histNxt;

  // hist[0] is the most recent output bit, hist[LAG-1] the one LAG bits back
  always_comb begin
    logic [LAG-1:0] h;
    logic           b;
    h    = hist;
    dOut = '0;
    for (int i = 0; i < W; i++) begin
      b       = en ? (dIn[i] ^ h[LAG-1]) : dIn[i];
      dOut[i] = b;
      h       = {h[LAG-2:0], b};
    end
    histNxt = h;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hist <= '0;
    else       hist <= histNxt;
  end

endmodule

// File: rtl/posTxCtrl.sv
module posTxCtrl
  import posTxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgReadEn,
  input  logic [1:0] cfgFcsSel,
  input  logic       cfgErrMode,
  input  logic       cfgAcPass,
  input  logic       errInjSet,
  input  logic       errInjClr,
  input  logic       fifoValid,
  input  logic       fifoSop,
  input  logic       fifoEop,
  input  logic       stall,
  output logic       fifoRd,
  output logic       frameBusy,
  output logic       errInjActive,
  output txStrobeT   strb
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_DATA,
    ST_FCS
  } stateT;

  stateT      state, stateNxt;
  logic [1:0] fcsIdx, fcsIdxNxt;
  logic       fcsOnQ;
  logic       wideQ;
  logic       corruptQ;
  logic       errInj;
  logic       startFrame;
  logic       lastFcs;
  logic       fcsDone;
  logic       adv;

  assign adv        = !stall;
  assign startFrame = (state == ST_IDLE) && adv && cfgReadEn && fifoValid && fifoSop;
  assign lastFcs    = (fcsIdx == (wideQ ? 2'd3 : 2'd1));
  assign fcsDone    = (state == ST_FCS) && adv && lastFcs;

  always_comb begin
    strb           = '0;
    strb.sel       = SEL_FLAG;
    strb.fcsIdx    = fcsIdx;
    strb.fcsInvert = corruptQ;
    strb.crc32     = wideQ;
    strb.crcInit   = startFrame;
    fifoRd         = 1'b0;
    stateNxt       = state;
    fcsIdxNxt      = fcsIdx;
    unique case (state)
      ST_IDLE: begin
        if (startFrame) stateNxt = cfgAcPass ? ST_DATA : ST_ADDR;
      end
      ST_ADDR: begin
        strb.sel       = SEL_ADDR;
        strb.frameByte = 1'b1;
        strb.crcUpd    = adv;
        if (adv) stateNxt = ST_CTRL;
      end
      ST_CTRL: begin
        strb.sel       = SEL_CTRL;
        strb.frameByte = 1'b1;
        strb.crcUpd    = adv;
        if (adv) stateNxt = ST_DATA;
      end
      ST_DATA: begin
        if (fifoValid) begin
          strb.sel       = SEL_DATA;
          strb.frameByte = 1'b1;
          fifoRd         = adv;
          strb.crcUpd    = adv;
          if (adv && fifoEop) stateNxt = fcsOnQ ? ST_FCS : ST_IDLE;
        end
      end
      ST_FCS: begin
        strb.sel       = SEL_FCS;
        strb.frameByte = 1'b1;
        if (adv) begin
          if (lastFcs) begin
            stateNxt  = ST_IDLE;
            fcsIdxNxt = 2'd0;
          end else begin
            fcsIdxNxt = fcsIdx + 2'd1;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fcsIdx   <= 2'd0;
      fcsOnQ   <= 1'b0;
      wideQ    <= 1'b0;
      corruptQ <= 1'b0;
      errInj   <= 1'b0;
    end else begin
      state  <= stateNxt;
      fcsIdx <= fcsIdxNxt;
      if (startFrame) begin
        fcsOnQ   <= cfgFcsSel[1];
        wideQ    <= cfgFcsSel[0];
        corruptQ <= errInj && cfgFcsSel[1];
      end
      if (errInjClr)                               errInj <= 1'b0;
      else if (errInjSet)                          errInj <= 1'b1;
      else if (fcsDone && corruptQ && !cfgErrMode) errInj <= 1'b0;
    end
  end

  assign frameBusy    = (state != ST_IDLE);
  assign errInjActive = errInj;

endmodule

// File: rtl/posTxDatapath.sv
module posTxDatapath
  import posTxPkg::*;
#(
  parameter int SCR_LAG = 43
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          strb,
  input  logic [BYTE_W-1:0] fifoData,
  input  logic              cfgScrEn,
  output logic              stall,
  output logic [BYTE_W-1:0] lineByte,
  output logic [BYTE_W-1:0] txData
);

  logic [31:0]       crc;
  logic [31:0]       fcsWord;
  logic [BYTE_W-1:0] curByte;
  logic [BYTE_W-1:0] escByte;
  logic              escPending;
  logic              needEsc;
  logic [BYTE_W-1:0] scrOut;

  assign fcsWord = strb.fcsInvert ? crc : ~crc;

  always_comb begin
    unique case (strb.sel)
      SEL_ADDR: curByte = ADDR_BYTE;
      SEL_CTRL: curByte = CTRL_BYTE;
      SEL_DATA: curByte = fifoData;
      SEL_FCS:  curByte = fcsWord[{strb.fcsIdx, 3'b000} +: BYTE_W];
      default:  curByte = FLAG_BYTE;
    endcase
  end

  assign needEsc = strb.frameByte && ((curByte == FLAG_BYTE) || (curByte == ESC_BYTE));

  always_comb begin
    if (escPending)   lineByte = escByte;
    else if (needEsc) lineByte = ESC_BYTE;
    else              lineByte = curByte;
  end

  assign stall = escPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      escPending <= 1'b0;
      escByte    <= '0;
      crc        <= '1;
    end else begin
      escPending <= !escPending && needEsc;
      if (!escPending && needEsc) escByte <= curByte ^ ESC_FLIP;
      if (strb.crcInit)     crc <= '1;
      else if (strb.crcUpd) crc <= crcStep(crc, curByte, strb.crc32);
    end
  end

  posTxScrambler #(.W(BYTE_W), .LAG(SCR_LAG)) uScr (
    .clk  (clk),
    .rstN (rstN),
    .en   (cfgScrEn),
    .dIn  (lineByte),
    .dOut (scrOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txData <= FLAG_BYTE;
    else       txData <= scrOut;
  end

endmodule

// File: rtl/posTxFramer.sv
module posTxFramer
  import posTxPkg::*;
#(
  parameter int SCR_LAG = 43
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgReadEn,
  input  logic [1:0] cfgFcsSel,
  input  logic       cfgErrMode,
  input  logic       cfgAcPass,
  input  logic       cfgScrEn,
  input  logic       errInjSet,
  input  logic       errInjClr,
  output logic       errInjActive,
  input  logic [7:0] fifoData,
  input  logic       fifoSop,
  input  logic       fifoEop,
  input  logic       fifoValid,
  output logic       fifoRd,
  output logic [7:0] txData
);

  txStrobeT          strb;
  logic              stall;
  logic              frameBusy;
  logic [BYTE_W-1:0] lineByte;

  posTxCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgReadEn    (cfgReadEn),
    .cfgFcsSel    (cfgFcsSel),
    .cfgErrMode   (cfgErrMode),
    .cfgAcPass    (cfgAcPass),
    .errInjSet    (errInjSet),
    .errInjClr    (errInjClr),
    .fifoValid    (fifoValid),
    .fifoSop      (fifoSop),
    .fifoEop      (fifoEop),
    .stall        (stall),
    .fifoRd       (fifoRd),
    .frameBusy    (frameBusy),
    .errInjActive (errInjActive),
    .strb         (strb)
  );

  posTxDatapath #(.SCR_LAG(SCR_LAG)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .fifoData (fifoData),
    .cfgScrEn (cfgScrEn),
    .stall    (stall),
    .lineByte (lineByte),
    .txData   (txData)
  );

endmodule

// File: rtl/posTxChecker.sv
module posTxChecker (
  input logic       clk,
  input logic       rstN,
  input logic       fifoRd,
  input logic       fifoValid,
  input logic       cfgReadEn,
  input logic       frameBusy,
  input logic       cfgScrEn,
  input logic       cfgErrMode,
  input logic       errInjClr,
  input logic       errInjActive,
  input logic [7:0] preScr,
  input logic [7:0] txData
);

  AST_RD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> fifoValid); // R10

  AST_NO_RD_ON_ESC: assert property (@(posedge clk) disable iff (!rstN)
    (preScr == 8'h7D) |=> !fifoRd); // R10

  AST_ESC_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (preScr == 8'h7D) |=> (preScr == 8'h5E || preScr == 8'h5D)); // R5

  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgReadEn && !frameBusy) |-> !fifoRd); // R2

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErrMode && errInjActive && !errInjClr) |=> errInjActive); // R7

  AST_ONESHOT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errInjActive) |-> ($past(errInjClr) || !$past(cfgErrMode))); // R6

  AST_SCR_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    !cfgScrEn |=> (txData == $past(preScr))); // R9

endmodule

bind posTxFramer posTxChecker uChk (
  .clk          (clk),
  .rstN         (rstN),
  .fifoRd       (fifoRd),
  .fifoValid    (fifoValid),
  .cfgReadEn    (cfgReadEn),
  .frameBusy    (frameBusy),
  .cfgScrEn     (cfgScrEn),
  .cfgErrMode   (cfgErrMode),
  .errInjClr    (errInjClr),
  .errInjActive (errInjActive),
  .preScr       (lineByte),
  .txData       (txData)
);

// File: tb/tb_posTxFramer.sv
module tb_posTxFramer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgReadEn = 1'b1;
  logic [1:0] cfgFcsSel = 2'b11;
  logic       cfgErrMode = 1'b0;
  logic       cfgAcPass = 1'b0;
  logic       cfgScrEn = 1'b0;
  logic       errInjSet = 1'b0;
  logic       errInjClr = 1'b0;
  logic       errInjActive;
  logic [7:0] fifoData = 8'h00;
  logic       fifoSop = 1'b0;
  logic       fifoEop = 1'b0;
  logic       fifoValid = 1'b0;
  logic       fifoRd;
  logic [7:0] txData;

  int checks = 0;
  int errors = 0;

  // FIFO model
  logic [7:0] fq[$];
  logic       fs[$];
  logic       fe[$];
  logic       rdLatched = 1'b0;
  int         rdCount = 0;
  int         rdBad = 0;
  int         pushed = 0;

  // expected frames
  logic [7:0] expBytes[$];
  int         expLen[$];
  logic       errModel = 1'b0;
  string      frameTag = "R4";

  // receiver
  logic       collecting = 1'b0;
  logic [42:0] dsHist = '0;
  logic [42:0] scHist = '0;
  logic [7:0] rxBuf[$];
  logic       rxEsc = 1'b0;
  int         rxFrames = 0;
  int         idleN = 0;
  int         idleBad = 0;

  always #2.5 clk = ~clk;

  posTxFramer dut (
    .clk(clk), .rstN(rstN), .cfgReadEn(cfgReadEn), .cfgFcsSel(cfgFcsSel),
    .cfgErrMode(cfgErrMode), .cfgAcPass(cfgAcPass), .cfgScrEn(cfgScrEn),
    .errInjSet(errInjSet), .errInjClr(errInjClr), .errInjActive(errInjActive),
    .fifoData(fifoData), .fifoSop(fifoSop), .fifoEop(fifoEop),
    .fifoValid(fifoValid), .fifoRd(fifoRd), .txData(txData)
  );

  function automatic logic [31:0] refFcs(input logic [7:0] f[$], input bit wide);
    logic [31:0] r;
    r = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    foreach (f[i]) begin
      for (int b = 0; b < 8; b++) begin
        if (r[0] != f[i][b]) r = (r >> 1) ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
        else                 r = r >> 1;
      end
    end
    return wide ? ~r : {16'h0000, ~r[15:0]};
  endfunction

  function automatic logic [7:0] scrModel(input logic [7:0] d);
    logic [7:0] o;
    for (int k = 0; k < 8; k++) begin
      o[k]   = d[k] ^ scHist[42];
      scHist = {scHist[41:0], o[k]};
    end
    return o;
  endfunction

  function automatic logic [7:0] descr(input logic [7:0] r);
    logic [7:0] o;
    for (int k = 0; k < 8; k++) begin
      o[k]   = r[k] ^ dsHist[42];
      dsHist = {dsHist[41:0], r[k]};
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic frameDone();
    int n;
    bit ok;
    int firstBad;
    logic [7:0] e;
    rxFrames++;
    if (expLen.size() == 0) begin
      check(1'b0, frameTag, "unexpected frame length", rxBuf.size(), 0);
    end else begin
      n = expLen.pop_front();
      ok = (rxBuf.size() == n);
      firstBad = -1;
      for (int i = 0; i < n; i++) begin
        e = expBytes.pop_front();
        if (i < rxBuf.size() && rxBuf[i] != e && firstBad < 0) begin
          firstBad = i;
          ok = 1'b0;
          $display("  byte %0d: got %02h expected %02h", i, rxBuf[i], e);
        end
      end
      check(ok, frameTag, "frame length", rxBuf.size(), n);
    end
    rxBuf.delete();
  endtask

  task automatic takeByte(input logic [7:0] raw);
    logic [7:0] p;
    logic [7:0] e;
    if (idleN < 16) begin
      e = cfgScrEn ? scrModel(8'h7E) : 8'h7E;
      if (raw != e) idleBad++;
      idleN++;
    end
    p = cfgScrEn ? descr(raw) : raw;
    if (p == 8'h7E) begin
      if (rxBuf.size() > 0) frameDone();
      rxEsc = 1'b0;
    end else if (p == 8'h7D) begin
      rxEsc = 1'b1;
    end else begin
      rxBuf.push_back(rxEsc ? (p ^ 8'h20) : p);
      rxEsc = 1'b0;
    end
  endtask

  // FIFO and line process, active around the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (collecting) takeByte(txData);
      if (rdLatched) begin
        void'(fq.pop_front());
        void'(fs.pop_front());
        void'(fe.pop_front());
        rdCount++;
      end
      if (fq.size() > 0) begin
        fifoValid = 1'b1; fifoData = fq[0]; fifoSop = fs[0]; fifoEop = fe[0];
      end else begin
        fifoValid = 1'b0; fifoData = 8'h00; fifoSop = 1'b0; fifoEop = 1'b0;
      end
      #1;
      rdLatched = fifoRd && rstN;
      if (fifoRd && !fifoValid) rdBad++;
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    collecting = 1'b0;
    fq.delete(); fs.delete(); fe.delete();
    expBytes.delete(); expLen.delete();
    step();
    step();
    check(txData == 8'h7E && !fifoRd && !errInjActive, "R11", "reset outputs",
          {txData, 6'd0, fifoRd, errInjActive}, {8'h7E, 8'h00});
    rstN = 1'b1;
    step();
    dsHist = '0; scHist = '0; rxBuf.delete(); rxEsc = 1'b0;
    idleN = 0; idleBad = 0; rxFrames = 0;
    rdCount = 0; rdBad = 0; pushed = 0; errModel = 1'b0;
    collecting = 1'b1;
  endtask

  task automatic sendPkt(input logic [7:0] pkt[$]);
    logic [7:0] frm[$];
    logic [31:0] f;
    bit corrupt;
    int nf;
    foreach (pkt[i]) begin
      fq.push_back(pkt[i]);
      fs.push_back(i == 0);
      fe.push_back(i == pkt.size() - 1);
    end
    pushed += pkt.size();
    frm = cfgAcPass ? pkt : {8'hFF, 8'h03, pkt};
    corrupt = errModel && cfgFcsSel[1];
    if (corrupt && !cfgErrMode) errModel = 1'b0;
    nf = (cfgFcsSel == 2'b11) ? 4 : (cfgFcsSel == 2'b10) ? 2 : 0;
    if (nf > 0) begin
      f = refFcs(frm, nf == 4);
      if (corrupt) f = ~f;
      for (int i = 0; i < nf; i++) frm.push_back(f[8*i +: 8]);
    end
    foreach (frm[i]) expBytes.push_back(frm[i]);
    expLen.push_back(frm.size());
  endtask

  task automatic sendRandom(input int maxLen);
    logic [7:0] pkt[$];
    int len;
    len = $urandom_range(maxLen, 1);
    for (int i = 0; i < len; i++) begin
      if (($urandom % 4) == 0) pkt.push_back(($urandom % 2) ? 8'h7E : 8'h7D);
      else                     pkt.push_back(8'($urandom));
    end
    sendPkt(pkt);
  endtask

  task automatic waitDone(input string tag);
    int i;
    for (i = 0; i < 8000; i++) begin
      if (fq.size() == 0 && expLen.size() == 0) break;
      step();
    end
    check(i < 8000, tag, "drain timeout", expLen.size(), 0);
    check(rdCount == pushed && rdBad == 0, "R10", "FIFO reads", rdCount, pushed);
  endtask

  task automatic pulseSet();
    errInjSet = 1'b1; step(); errInjSet = 1'b0; step();
    errModel = 1'b1;
  endtask

  task automatic pulseClr();
    errInjClr = 1'b1; step(); errInjClr = 1'b0; step();
    errModel = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 idle flags unscrambled, then stuffing and generated fields
    cfgScrEn = 1'b0; cfgFcsSel = 2'b11; cfgAcPass = 1'b0;
    doReset();
    repeat (20) step();
    check(idleBad == 0 && rxFrames == 0, "R1", "idle flags", idleBad, 0);
    frameTag = "R5";
    sendPkt('{8'h7E, 8'h7D, 8'h00, 8'h20, 8'h5E});
    sendPkt('{8'h7D});
    frameTag = "R3";
    sendPkt('{8'h55});
    waitDone("R5");

    // R9 scrambled idle, then CRC-16 traffic
    cfgScrEn = 1'b1; cfgFcsSel = 2'b10;
    doReset();
    repeat (20) step();
    check(idleBad == 0, "R9", "scrambled idle bytes", idleBad, 0);
    frameTag = "R9";
    for (int i = 0; i < 5; i++) sendRandom(24);
    waitDone("R9");

    // R3 pass-through with no FCS, R4 reserved select
    cfgScrEn = 1'b0; cfgAcPass = 1'b1; cfgFcsSel = 2'b00;
    doReset();
    frameTag = "R3";
    sendPkt('{8'h11, 8'h22, 8'h7E});
    sendRandom(10);
    waitDone("R3");
    cfgFcsSel = 2'b01;
    frameTag = "R4";
    sendPkt('{8'hA5, 8'h7D});
    waitDone("R4");

    // R2 read enable
    cfgAcPass = 1'b0; cfgFcsSel = 2'b11; cfgReadEn = 1'b0;
    doReset();
    frameTag = "R2";
    sendPkt('{8'h01, 8'h02, 8'h03});
    repeat (100) step();
    check(rdCount == 0 && rxFrames == 0, "R2", "reads while disabled", rdCount, 0);
    cfgReadEn = 1'b1;
    waitDone("R2");
    check(rxFrames == 1, "R2", "frame after enable", rxFrames, 1);

    // R6 one-shot corruption
    cfgScrEn = 1'b1; cfgErrMode = 1'b0;
    doReset();
    pulseSet();
    check(errInjActive == 1'b1, "R6", "request set", errInjActive, 1);
    frameTag = "R6";
    for (int i = 0; i < 3; i++) sendRandom(12);
    waitDone("R6");
    check(errInjActive == 1'b0, "R6", "request self-cleared", errInjActive, 0);

    // R7 sticky corruption
    cfgErrMode = 1'b1; cfgFcsSel = 2'b10;
    doReset();
    pulseSet();
    frameTag = "R7";
    for (int i = 0; i < 3; i++) sendRandom(12);
    waitDone("R7");
    check(errInjActive == 1'b1, "R7", "request held", errInjActive, 1);
    pulseClr();
    check(errInjActive == 1'b0, "R7", "request cleared", errInjActive, 0);
    sendRandom(8);
    waitDone("R7");

    // R8 no FCS leaves request pending
    cfgErrMode = 1'b0; cfgFcsSel = 2'b00;
    doReset();
    pulseSet();
    frameTag = "R8";
    for (int i = 0; i < 2; i++) sendRandom(10);
    waitDone("R8");
    check(errInjActive == 1'b1, "R8", "request untouched", errInjActive, 1);

    // R4 random configurations
    frameTag = "R4";
    for (int ph = 0; ph < 10; ph++) begin
      cfgFcsSel = 2'($urandom);
      cfgAcPass = 1'($urandom);
      cfgScrEn  = 1'($urandom);
      cfgErrMode = 1'b0;
      doReset();
      for (int i = 0; i < 5; i++) sendRandom(32);
      waitDone("R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule